// File: doc/BRIEF.md
# I2C Slave Address Matcher with Bus Monitor

This block sits beside the synchronizer flops of a two-wire serial port. It watches the clock and data lines for START and STOP conditions and keeps a bus-busy flag from them. In slave mode it shifts in the first byte after every START. It compares the upper seven bits with a programmed own address and acknowledges when they match.

After a match it latches the direction bit. From then on it moves whole bytes in the chosen direction. Between bytes it stretches the clock by holding SCL low, until the host touches the data register in the way that fits the direction.

The line outputs are pull-down requests for open-drain pads. The inputs are the already synchronized line levels. Host accesses arrive as single-cycle strobes. The master side of the port is a separate engine and is not part of this block.

Top module: `i2c_slave_mon`

## Requirements
- R1: A START is seen when SDA falls while SCL is high in this and the previous cycle. A STOP is seen when SDA rises under the same SCL condition. `busy` goes to 1 on a START and to 0 on a STOP.
- R2: The first byte after a START is received MSB first, one bit per SCL rising edge. Bits [7:1] form the 7-bit address and bit 0 is the read/write bit. `rx_byte` holds each byte the block receives, the address byte included, from its 8th rising edge on.
- R3: When bits [7:1] equal `own_addr`, the block pulls SDA low for the ninth clock, whatever `ack_off` is. At the ninth falling edge it sets `addressed` and copies bit 0 into `srw`: 1 means slave transmit, 0 means slave receive.
- R4: When the address differs, SDA stays released for the ninth clock and the clock is not held. Later data bytes are neither acknowledged nor stretched until the next START or STOP.
- R5: `addressed` is set only at the end of a matching address byte. A `ctrl_wr` strobe clears it, and the clear wins over a set in the same cycle.
- R6: The block holds SCL low after the ninth falling edge of three kinds of byte: a matching address byte, a received data byte, and a transmitted byte that the master acknowledged. Only `data_rd` (when `srw`=0) or `data_wr` (when `srw`=1) releases the hold. The other strobe leaves SCL held.
- R7: In slave receive, each data byte is shifted in. On its ninth clock SDA is pulled low when `ack_off`=0 and left released when `ack_off`=1.
- R8: In slave transmit, `data_wr` loads `tx_data` and the MSB appears on SDA before the next SCL rise. The pull-down changes only while SCL is low. A master acknowledge (SDA low on the ninth clock) leads to a new hold. A master non-acknowledge releases both lines and the block ignores the bus until START or STOP.
- R9: `byte_done` is 1 after reset. It goes to 0 at the first SCL rising edge of a byte the block takes part in, and to 1 at that byte's ninth falling edge.
- R10: A repeated START (a START while `busy`=1) restarts address reception from any state and leaves `busy` at 1.
- R11: With `enable`=0 all outputs take their reset values. A transfer that is under way when `enable` rises is ignored: `busy` stays 0 and nothing is acknowledged until the next START.
- R12: After reset the block is an idle slave receiver: both pull-downs are off, `busy`, `addressed`, `srw` and `rx_byte` are 0, and `byte_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Block enable; low acts as a reset of the slave logic |
| sda_in | input | 1 | Synchronized SDA bus level |
| scl_in | input | 1 | Synchronized SCL bus level |
| own_addr | input | DATA_W-1 | Address this slave answers to |
| ack_off | input | 1 | 1 = do not acknowledge received data bytes |
| ctrl_wr | input | 1 | Strobe: host wrote the control register |
| data_rd | input | 1 | Strobe: host read the data register |
| data_wr | input | 1 | Strobe: host wrote the data register |
| tx_data | input | DATA_W | Byte written by the host, taken on `data_wr` |
| sda_pull | output | 1 | Pull SDA low |
| scl_pull | output | 1 | Pull SCL low (clock stretch) |
| busy | output | 1 | Bus is between START and STOP |
| addressed | output | 1 | Addressed as slave |
| srw | output | 1 | Latched read/write bit, 1 = slave transmit |
| byte_done | output | 1 | Last byte transfer finished |
| rx_byte | output | DATA_W | Last received byte |

## Verification
The assertions take `scl_in` to be the wired-AND bus level. It therefore reads low whenever `scl_pull` is set, and no START or STOP can appear while the block stretches the clock. They also assume that the master changes SDA only while SCL is low, except for deliberate START and STOP conditions. The bench keeps to this by forming both lines as the AND of a master model and the block's pull-downs. Its master moves SDA only during the low phase and waits for SCL to read high before it times the high phase. It issues host strobes only while the line it is about to clock is low.

// File: rtl/i2cmon_pkg.sv
// Shared types for the slave address matcher.
// Assumes nothing beyond the standard two-wire byte framing.
package i2cmon_pkg;

    // Sequencer states of the slave engine
    typedef enum logic [3:0] {
        ST_IDLE,      // waiting for a START
        ST_ADDR,      // shifting in the address byte
        ST_ADDR_ACK,  // ninth clock of the address byte
        ST_HOLD,      // clock stretched, waiting for host access
        ST_RX,        // shifting in a data byte
        ST_RX_ACK,    // ninth clock of a received byte
        ST_TX,        // shifting out a data byte
        ST_TX_ACK,    // ninth clock, master acknowledge
        ST_SKIP       // not our transfer, wait for START/STOP
    } slv_state_e;

endpackage

// File: rtl/i2cmon_line_watch.sv
// Line watcher: edge detection on SCL and START/STOP detection,
// plus the bus-busy flag.
// Assumes sda_in/scl_in are already synchronized to clk.
module i2cmon_line_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic sda_in,
    input  logic scl_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic busy
);

    logic sda_q;
    logic scl_q;

    // Previous line levels; track even while disabled so that enabling
    // never produces a false edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_q <= 1'b1;
            scl_q <= 1'b1;
        end else begin
            sda_q <= sda_in;
            scl_q <= scl_in;
        end
    end

    assign scl_rise  = scl_in & ~scl_q;
    assign scl_fall  = ~scl_in & scl_q;
    assign start_det = enable & scl_in & scl_q & sda_q & ~sda_in;
    assign stop_det  = enable & scl_in & scl_q & ~sda_q & sda_in;

    // Bus-busy flag from START and STOP
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            busy <= 1'b0;
        end else if (start_det) begin
            busy <= 1'b1;
        end else if (stop_det) begin
            busy <= 1'b0;
        end
    end

endmodule

// File: rtl/i2cmon_bit_count.sv
// Bit counter for the byte sequencer: clear has priority over count.
// Assumes the controller never counts past its own limit.
module i2cmon_bit_count #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    // Count bits within the current byte
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/i2cmon_addr_match.sv
// Address comparator: the upper bits of the received frame against the
// programmed own address, one equality cell per bit.
// Assumes frame holds a complete byte, MSB received first.
module i2cmon_addr_match #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] frame,
    input  logic [DATA_W-2:0] own,
    output logic              hit,
    output logic              rw
);

    localparam int AW = DATA_W - 1;

    logic [AW-1:0] eq;

    for (genvar i = 0; i < AW; i++) begin : g_bit
        assign eq[i] = ~(frame[i+1] ^ own[i]);
    end

    assign hit = &eq;
    assign rw  = frame[0];

endmodule

// File: rtl/i2cmon_slave_fsm.sv
// Slave sequencer: address reception, acknowledge generation, clock
// stretching between bytes, data shift in both directions.
// Assumes SCL edges and START/STOP come from the line watcher and that
// host strobes are single-cycle pulses.
module i2cmon_slave_fsm
    import i2cmon_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              sda_in,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              ack_off,
    input  logic              ctrl_wr,
    input  logic              data_rd,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              hit,
    input  logic              rw_bit,
    input  logic [CNT_W-1:0]  cnt,
    output logic              cnt_clr,
    output logic              cnt_inc,
    output logic [DATA_W-1:0] sh,
    output logic              sda_pull,
    output logic              scl_pull,
    output logic              addressed,
    output logic              srw,
    output logic              byte_done,
    output logic [DATA_W-1:0] rx_byte
);

    localparam logic [CNT_W-1:0] BITS     = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    slv_state_e st;
    logic       hit_q;
    logic       mack;
    logic       release_ok;

    // Host access that ends a clock stretch for the latched direction
    assign release_ok = srw ? data_wr : data_rd;

    // Bit counter control per state
    always_comb begin
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        if (!enable || start_det || stop_det) begin
            cnt_clr = 1'b1;
        end else begin
            case (st)
                ST_ADDR, ST_RX: cnt_inc = scl_rise && (cnt < BITS);
                ST_TX:          cnt_inc = scl_fall && (cnt < LAST_BIT);
                default:        cnt_clr = 1'b1;
            endcase
        end
    end

    // Main sequencer, line drives and host-visible flags
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            st        <= ST_IDLE;
            sh        <= '0;
            rx_byte   <= '0;
            addressed <= 1'b0;
            srw       <= 1'b0;
            byte_done <= 1'b1;
            sda_pull  <= 1'b0;
            scl_pull  <= 1'b0;
            hit_q     <= 1'b0;
            mack      <= 1'b0;
        end else begin
            if (start_det) begin
                st       <= ST_ADDR;
                sda_pull <= 1'b0;
                scl_pull <= 1'b0;
            end else if (stop_det) begin
                st       <= ST_IDLE;
                sda_pull <= 1'b0;
                scl_pull <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR, ST_RX: begin
                        if (scl_rise && (cnt < BITS)) begin
                            sh <= {sh[DATA_W-2:0], sda_in};
                            if (cnt == '0) begin
                                byte_done <= 1'b0;
                            end
                            if (cnt == LAST_BIT) begin
                                rx_byte <= {sh[DATA_W-2:0], sda_in};
                            end
                        end else if (scl_fall && (cnt == BITS)) begin
                            if (st == ST_ADDR) begin
                                hit_q    <= hit;
                                sda_pull <= hit;
                                st       <= ST_ADDR_ACK;
                            end else begin
                                sda_pull <= ~ack_off;
                                st       <= ST_RX_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            sda_pull  <= 1'b0;
                            byte_done <= 1'b1;
                            if (hit_q) begin
                                addressed <= 1'b1;
                                srw       <= rw_bit;
                                scl_pull  <= 1'b1;
                                st        <= ST_HOLD;
                            end else begin
                                st <= ST_SKIP;
                            end
                        end
                    end
                    ST_HOLD: begin
                        if (release_ok) begin
                            scl_pull <= 1'b0;
                            if (srw) begin
                                sh       <= tx_data;
                                sda_pull <= ~tx_data[DATA_W-1];
                                st       <= ST_TX;
                            end else begin
                                st <= ST_RX;
                            end
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            sda_pull  <= 1'b0;
                            byte_done <= 1'b1;
                            scl_pull  <= 1'b1;
                            st        <= ST_HOLD;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise && (cnt == '0)) begin
                            byte_done <= 1'b0;
                        end
                        if (scl_fall) begin
                            if (cnt == LAST_BIT) begin
                                sda_pull <= 1'b0;
                                st       <= ST_TX_ACK;
                            end else begin
                                sh       <= {sh[DATA_W-2:0], 1'b0};
                                sda_pull <= ~sh[DATA_W-2];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_in;
                        end else if (scl_fall) begin
                            byte_done <= 1'b1;
                            if (mack) begin
                                scl_pull <= 1'b1;
                                st       <= ST_HOLD;
                            end else begin
                                st <= ST_SKIP;
                            end
                        end
                    end
                    default: begin
                        st <= st;
                    end
                endcase
            end
            if (ctrl_wr) begin
                addressed <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/i2c_slave_mon.sv
// Top: slave address matcher with bus monitor for a two-wire port.
// Assumes synchronized line inputs and open-drain pads driven by the
// pull outputs; the master engine lives elsewhere.
module i2c_slave_mon #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              sda_in,
    input  logic              scl_in,
    input  logic [DATA_W-2:0] own_addr,
    input  logic              ack_off,
    input  logic              ctrl_wr,
    input  logic              data_rd,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] tx_data,
    output logic              sda_pull,
    output logic              scl_pull,
    output logic              busy,
    output logic              addressed,
    output logic              srw,
    output logic              byte_done,
    output logic [DATA_W-1:0] rx_byte
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              cnt_clr;
    logic              cnt_inc;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] sh;
    logic              hit;
    logic              rw_bit;

    i2cmon_line_watch u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .sda_in    (sda_in),
        .scl_in    (scl_in),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .busy      (busy)
    );

    i2cmon_bit_count #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    i2cmon_addr_match #(.DATA_W(DATA_W)) u_match (
        .frame (sh),
        .own   (own_addr),
        .hit   (hit),
        .rw    (rw_bit)
    );

    i2cmon_slave_fsm #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .sda_in    (sda_in),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .ack_off   (ack_off),
        .ctrl_wr   (ctrl_wr),
        .data_rd   (data_rd),
        .data_wr   (data_wr),
        .tx_data   (tx_data),
        .hit       (hit),
        .rw_bit    (rw_bit),
        .cnt       (cnt),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc),
        .sh        (sh),
        .sda_pull  (sda_pull),
        .scl_pull  (scl_pull),
        .addressed (addressed),
        .srw       (srw),
        .byte_done (byte_done),
        .rx_byte   (rx_byte)
    );

endmodule

// File: rtl/i2cmon_checker.sv
// Property checker for i2c_slave_mon, attached by bind.
// Assumes scl_in is the wired bus level, so it is low while scl_pull is set.
module i2cmon_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic scl_in,
    input logic start_det,
    input logic stop_det,
    input logic busy,
    input logic sda_pull,
    input logic scl_pull,
    input logic data_rd,
    input logic data_wr,
    input logic ctrl_wr,
    input logic addressed,
    input logic byte_done
);

    // R1: START raises busy
    a_r1_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (busy || !enable));

    // R1: STOP drops busy
    a_r1_idle_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !busy);

    // R6: a stretch is only ended by a host data access
    a_r6_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pull && enable && !data_rd && !data_wr) |=> scl_pull);

    // R8: the SDA pull-down only moves while SCL is low
    a_r8_sda_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && !$stable(sda_pull)) |-> !scl_in);

    // R9: byte completion is flagged in the low phase of SCL
    a_r9_done_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(byte_done) && enable && $past(enable)) |-> !scl_in);

    // R3: addressed rises together with byte completion
    a_r3_addr_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addressed) |-> $rose(byte_done));

    // R5: control write clears addressed
    a_r5_ctrl_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !addressed);

    // R11: disabled block shows reset values
    a_r11_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!busy && !addressed && byte_done && !scl_pull && !sda_pull));

endmodule

bind i2c_slave_mon i2cmon_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .scl_in    (scl_in),
    .start_det (start_det),
    .stop_det  (stop_det),
    .busy      (busy),
    .sda_pull  (sda_pull),
    .scl_pull  (scl_pull),
    .data_rd   (data_rd),
    .data_wr   (data_wr),
    .ctrl_wr   (ctrl_wr),
    .addressed (addressed),
    .byte_done (byte_done)
);

// File: tb/i2c_slave_mon_tb.sv
// Bench: wired-AND bus with a master model, directed corners and
// seeded random transactions.
module i2c_slave_mon_tb;

    localparam int H = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       sda_m = 1'b1;
    logic       scl_m = 1'b1;
    logic       ack_off = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic       data_rd = 1'b0;
    logic       data_wr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic [6:0] own = 7'h2C;
    logic       sda_in;
    logic       scl_in;
    logic       sda_pull;
    logic       scl_pull;
    logic       busy;
    logic       addressed;
    logic       srw;
    logic       byte_done;
    logic [7:0] rx_byte;

    int checks = 0;
    int fails  = 0;

    assign sda_in = sda_m & ~sda_pull;
    assign scl_in = scl_m & ~scl_pull;

    always #10 clk = ~clk;

    i2c_slave_mon u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .sda_in    (sda_in),
        .scl_in    (scl_in),
        .own_addr  (own),
        .ack_off   (ack_off),
        .ctrl_wr   (ctrl_wr),
        .data_rd   (data_rd),
        .data_wr   (data_wr),
        .tx_data   (tx_data),
        .sda_pull  (sda_pull),
        .scl_pull  (scl_pull),
        .busy      (busy),
        .addressed (addressed),
        .srw       (srw),
        .byte_done (byte_done),
        .rx_byte   (rx_byte)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_in) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; wait_n(H);
        scl_m = 1'b1; wait_scl_high(); wait_n(H);
        sda_m = 1'b0; wait_n(H);
        scl_m = 1'b0; wait_n(H);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wait_n(H);
        scl_m = 1'b1; wait_scl_high(); wait_n(H);
        sda_m = 1'b1; wait_n(H);
    endtask

    task automatic m_bit(input logic b, output logic s);
        sda_m = b; wait_n(H);
        scl_m = 1'b1; wait_scl_high(); wait_n(H/2);
        s = sda_in; wait_n(H/2);
        scl_m = 1'b0; wait_n(H);
    endtask

    task automatic m_write(input logic [7:0] v, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) m_bit(v[i], s);
        m_bit(1'b1, ack);
    endtask

    task automatic m_read(input logic nack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, s);
            v[i] = s;
        end
        m_bit(nack, s);
    endtask

    task automatic host_rd();
        data_rd = 1'b1; wait_n(1); data_rd = 1'b0; wait_n(2);
    endtask

    task automatic host_wr(input logic [7:0] v);
        tx_data = v; data_wr = 1'b1; wait_n(1); data_wr = 1'b0; wait_n(2);
    endtask

    task automatic host_ctrl();
        ctrl_wr = 1'b1; wait_n(1); ctrl_wr = 1'b0; wait_n(2);
    endtask

    function automatic logic exp_match(input logic [6:0] a, input logic [6:0] o);
        return a == o;
    endfunction

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog all requirements actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic       s;
        logic       ack;
        logic [7:0] got;
        void'($urandom(32'd4242));
        enable = 1'b1;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(2);

        // R12 reset state
        chk("R12 busy", busy, 0);
        chk("R12 addressed", addressed, 0);
        chk("R12 srw", srw, 0);
        chk("R12 byte_done", byte_done, 1);
        chk("R12 sda_pull", sda_pull, 0);
        chk("R12 scl_pull", scl_pull, 0);
        chk("R12 rx_byte", rx_byte, 0);

        // R1 START, R9 mid-byte clear, R2/R3 address match for write
        m_start();
        chk("R1 busy after START", busy, 1);
        m_bit(own[6], s);
        chk("R9 byte_done cleared mid-byte", byte_done, 0);
        for (int i = 5; i >= 0; i--) m_bit(own[i], s);
        m_bit(1'b0, s);
        m_bit(1'b1, ack);
        chk("R3 address ack", ack, 0);
        chk("R3 addressed", addressed, 1);
        chk("R3 srw write", srw, 0);
        chk("R9 byte_done after ninth", byte_done, 1);
        chk("R2 rx_byte holds address", rx_byte, {own, 1'b0});
        wait_n(2);
        chk("R6 hold after address", scl_pull, 1);

        // R6 wrong access keeps the hold, right access releases
        host_wr(8'hFF);
        chk("R6 data_wr ignored in receive", scl_pull, 1);
        host_rd();
        chk("R6 data_rd releases", scl_pull, 0);

        // R7 data receive with acknowledge
        m_write(8'hA5, ack);
        chk("R7 data ack", ack, 0);
        chk("R7 rx_byte", rx_byte, 8'hA5);
        wait_n(2);
        chk("R6 hold after data", scl_pull, 1);

        // R5 control write clears addressed
        host_ctrl();
        chk("R5 ctrl_wr clears addressed", addressed, 0);

        // R7 acknowledge suppressed
        host_rd();
        ack_off = 1'b1;
        m_write(8'h3C, ack);
        chk("R7 ack_off gives no ack", ack, 1);
        chk("R7 rx_byte second", rx_byte, 8'h3C);

        // R10 repeated START, R3 address ack ignores ack_off
        host_rd();
        m_start();
        chk("R10 busy stays after repeated START", busy, 1);
        m_write({own, 1'b1}, ack);
        chk("R3 address ack with ack_off set", ack, 0);
        chk("R10 srw transmit after repeated START", srw, 1);
        ack_off = 1'b0;

        // R8 transmit: acked byte holds, R6 wrong access ignored
        host_wr(8'h96);
        m_read(1'b0, got);
        chk("R8 transmitted byte", got, 8'h96);
        wait_n(2);
        chk("R8 hold after master ack", scl_pull, 1);
        host_rd();
        chk("R6 data_rd ignored in transmit", scl_pull, 1);
        host_wr(8'h41);
        m_read(1'b1, got);
        chk("R8 second transmitted byte", got, 8'h41);
        wait_n(2);
        chk("R8 no hold after master nack", scl_pull, 0);
        chk("R8 sda released after nack", sda_pull, 0);
        m_stop();
        chk("R1 busy clear after STOP", busy, 0);

        // R4 mismatch
        host_ctrl();
        m_start();
        m_write({own ^ 7'h11, 1'b0}, ack);
        chk("R4 no ack on mismatch", ack, 1);
        chk("R4 not addressed", addressed, 0);
        chk("R4 no hold on mismatch", scl_pull, 0);
        m_write(8'h00, ack);
        chk("R4 data ignored", ack, 1);
        m_stop();

        // R11 disable mid-byte
        m_start();
        m_bit(own[6], s);
        enable = 1'b0;
        wait_n(2);
        chk("R11 busy off when disabled", busy, 0);
        chk("R11 byte_done when disabled", byte_done, 1);
        m_stop();

        // R11 enable in the middle of an address byte
        m_start();
        for (int i = 6; i >= 4; i--) m_bit(own[i], s);
        enable = 1'b1;
        for (int i = 3; i >= 0; i--) m_bit(own[i], s);
        m_bit(1'b0, s);
        m_bit(1'b1, ack);
        chk("R11 late enable ignores transfer", ack, 1);
        chk("R11 busy not set without START", busy, 0);
        chk("R11 not addressed", addressed, 0);
        m_stop();
        m_start();
        m_write({own, 1'b0}, ack);
        chk("R11 works from next START", ack, 0);
        host_rd();
        m_stop();

        // Random transactions
        for (int t = 0; t < 30; t++) begin
            logic [6:0] a;
            logic       rw;
            logic       em;
            logic [7:0] d;
            int         nb;
            a  = ($urandom % 2 == 0) ? own : 7'($urandom);
            rw = 1'($urandom);
            em = exp_match(a, own);
            nb = 1 + int'($urandom % 3);
            host_ctrl();
            m_start();
            m_write({a, rw}, ack);
            chk("R3 random address ack", ack, int'(!em));
            chk("R3 random addressed", addressed, int'(em));
            chk("R2 random rx_byte", rx_byte, {a, rw});
            if (!em) begin
                m_write(8'($urandom), ack);
                chk("R4 random data ignored", ack, 1);
                chk("R4 random no hold", scl_pull, 0);
            end else if (!rw) begin
                chk("R3 random srw", srw, 0);
                for (int b = 0; b < nb; b++) begin
                    host_rd();
                    ack_off = 1'($urandom);
                    d = 8'($urandom);
                    m_write(d, ack);
                    chk("R7 random ack", ack, int'(ack_off));
                    chk("R7 random rx_byte", rx_byte, d);
                    wait_n(2);
                    chk("R6 random hold", scl_pull, 1);
                end
                host_rd();
            end else begin
                chk("R3 random srw", srw, 1);
                for (int b = 0; b < nb; b++) begin
                    d = 8'($urandom);
                    host_wr(d);
                    m_read(b == nb - 1, got);
                    chk("R8 random tx byte", got, d);
                    wait_n(2);
                    chk("R8 random hold", scl_pull, int'(b != nb - 1));
                end
            end
            m_stop();
            chk("R1 random busy after STOP", busy, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule